// File: doc/BRIEF.md
# Period-Compare Touch Change Detector

This block turns the square wave of a capacitive relaxation oscillator into a touch/no-touch decision. The block times each high phase of the oscillator with the system clock. Successive timings are written in turn into two storage slots, and the two slots are compared bit by bit. A finger on the sensor line changes the oscillator period, so the two slots disagree and some difference bits go high. An untouched line gives the same timing every period and a zero difference.

The decision depends only on the change between consecutive measurements. The absolute count, which shifts with process and device spread from line to line, therefore never needs a per-line trim. The oscillator input is asynchronous and is synchronized inside the block. Dropping the count LSB before storage absorbs one clock of jitter.

Top module: `touch_period_cmp`

## Requirements
- R1: The count output is cleared to 0 while the synchronized oscillator is low. It increments by one on every clock edge at which the synchronized oscillator is high. The synchronizer has two flops, so a high phase lasting H clock periods at the input gives a count of H, read two cycles after the input falls.
- R2: The count saturates at 127 and does not wrap while the oscillator stays high.
- R3: A sticky overflow flag is set when the count reaches 127. It stays set until reset.
- R4: After reset, the first completed measurement is written into slot A and the second into slot B, and the slots keep alternating. The write happens on the clock after the synchronized falling edge of the oscillator. The slot that is not written keeps its value.
- R5: The stored value is the count with its LSB dropped, that is, count bits 6..1 (count divided by two). This gives 10 for counts of 20 and 21, and 63 for a count of 127.
- R6: While the synchronized oscillator is low, the difference output is slot A XOR slot B. While it is high, the difference output is 0.
- R7: The difference output is 0 until both slots have each received a measurement since reset.
- R8: The touch flag is 1 exactly when any difference bit is 1.
- R9: An active-low reset clears the count, both slots, the difference output, the touch flag, the overflow flag and the slot selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| osc_in | input | 1 | Digitized oscillator square wave (asynchronous) |
| count_o | output | 7 | Running high-phase count |
| slot_a_o | output | 6 | Stored measurement, slot A |
| slot_b_o | output | 6 | Stored measurement, slot B |
| diff_o | output | 6 | Bitwise difference of the slots |
| touch_o | output | 1 | Any difference bit set |
| ovf_o | output | 1 | Sticky count-saturation flag |

## Verification
The bench checks that counts of 20 and 21 collapse to the same stored value. A design that kept the LSB would report a touch there. It probes the difference output in the middle of a high phase while the slots disagree. A design that did not gate the comparison would show a nonzero difference at that point. A long high phase checks that the count stops at 127 and that the overflow flag stays set afterwards. A wrapping counter would store a small, aliased value. The bench also checks that the first measurement after reset, including after a mid-run reset, gives no difference. A design that compared against a cleared slot would report a false touch.

// File: rtl/touch_period_cmp.sv
module touch_period_cmp #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_in,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-2:0] slot_a_o,
  output logic [CNT_W-2:0] slot_b_o,
  output logic [CNT_W-2:0] diff_o,
  output logic             touch_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - 1'b1;

  logic [2:0] sync_q;
  logic       osc_hi, rise, fall;
  logic       sel_q, fill_a, fill_b;

  assign osc_hi = sync_q[1];
  assign rise   = sync_q[1] & ~sync_q[2];
  assign fall   = ~sync_q[1] & sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], osc_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count_o <= '0;
    else if (!osc_hi)       count_o <= '0;
    else if (count_o != CNT_MAX) count_o <= count_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ovf_o <= 1'b0;
    else if (osc_hi && count_o == CNT_PRE) ovf_o <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= 1'b0;
    else if (rise) sel_q <= ~sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_a_o <= '0;
      slot_b_o <= '0;
      fill_a   <= 1'b0;
      fill_b   <= 1'b0;
    end else if (fall) begin
      if (sel_q) begin
        slot_a_o <= count_o[CNT_W-1:1];
        fill_a   <= 1'b1;
      end else begin
        slot_b_o <= count_o[CNT_W-1:1];
        fill_b   <= 1'b1;
      end
    end
  end

  assign diff_o  = (fill_a && fill_b && !osc_hi) ? (slot_a_o ^ slot_b_o) : '0;
  assign touch_o = |diff_o;
endmodule

module touch_period_cmp_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_hi,
  input logic             fall,
  input logic             sel_q,
  input logic             fill_a,
  input logic             fill_b,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-2:0] slot_a_o,
  input logic [CNT_W-2:0] slot_b_o,
  input logic [CNT_W-2:0] diff_o,
  input logic             touch_o,
  input logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r1_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_hi |=> count_o == '0);
  a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_hi && count_o == CNT_MAX) |=> count_o == CNT_MAX);
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  a_r4_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot_a_o) |-> $past(fall && sel_q));
  a_r4_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot_b_o) |-> $past(fall && !sel_q));
  a_r6_gated_high: assert property (@(posedge clk) disable iff (!rst_n)
    osc_hi |-> diff_o == '0);
  a_r7_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_a && fill_b) |-> diff_o == '0);
  a_r8_touch_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(touch_o) |-> !osc_hi);
endmodule

bind touch_period_cmp touch_period_cmp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_hi(osc_hi), .fall(fall), .sel_q(sel_q),
  .fill_a(fill_a), .fill_b(fill_b), .count_o(count_o), .slot_a_o(slot_a_o),
  .slot_b_o(slot_b_o), .diff_o(diff_o), .touch_o(touch_o), .ovf_o(ovf_o)
);

// File: tb/touch_period_cmp_tb.sv
module touch_period_cmp_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_in = 1'b0;
  logic [6:0] count_o;
  logic [5:0] slot_a_o, slot_b_o, diff_o;
  logic       touch_o, ovf_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int last_cnt;

  always #4 clk = ~clk;

  touch_period_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .count_o(count_o),
    .slot_a_o(slot_a_o), .slot_b_o(slot_b_o), .diff_o(diff_o),
    .touch_o(touch_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int h, input int l);
    @(negedge clk) osc_in = 1'b1;
    repeat (h) @(negedge clk);
    osc_in = 1'b0;
    repeat (2) @(negedge clk);
    last_cnt = count_o;
    repeat (l - 2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 count", count_o, 0);
    chk("R9 slot_a", slot_a_o, 0);
    chk("R9 slot_b", slot_b_o, 0);
    chk("R9 diff", diff_o, 0);
    chk("R9 touch", touch_o, 0);
    chk("R9 ovf", ovf_o, 0);
  endtask

  task automatic t_first;
    pulse(20, 8);
    chk("R1 count 20", last_cnt, 20);
    chk("R4 first to A", slot_a_o, 10);
    chk("R4 B untouched", slot_b_o, 0);
    chk("R7 unarmed diff", diff_o, 0);
    chk("R7 unarmed touch", touch_o, 0);
  endtask

  task automatic t_lsb_drop;
    pulse(21, 8);
    chk("R5 21 halves to 10", slot_b_o, 10);
    chk("R4 A held", slot_a_o, 10);
    chk("R5 equal no diff", diff_o, 0);
    chk("R8 no touch", touch_o, 0);
  endtask

  task automatic t_change;
    pulse(30, 8);
    chk("R4 back to A", slot_a_o, 15);
    chk("R4 B held", slot_b_o, 10);
    chk("R6 diff xor", diff_o, 5);
    chk("R8 touch", touch_o, 1);
  endtask

  task automatic t_gate_high;
    @(negedge clk) osc_in = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 diff gated while high", diff_o, 0);
    chk("R8 touch gated while high", touch_o, 0);
    repeat (25) @(negedge clk);
    osc_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 B gets 15", slot_b_o, 15);
    chk("R6 equal slots", diff_o, 0);
    chk("R3 ovf still clear", ovf_o, 0);
  endtask

  task automatic t_saturate;
    pulse(200, 8);
    chk("R2 count sat", last_cnt, 127);
    chk("R3 ovf set", ovf_o, 1);
    chk("R5 sat stored", slot_a_o, 63);
    chk("R6 diff after sat", diff_o, 48);
    pulse(10, 8);
    chk("R3 ovf sticky", ovf_o, 1);
    chk("R4 B after sat", slot_b_o, 5);
    chk("R6 diff 63^5", diff_o, 58);
  endtask

  task automatic t_midreset;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    pulse(40, 8);
    chk("R4 after reset to A", slot_a_o, 20);
    chk("R7 unarmed after reset", diff_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_first();
    t_lsb_drop();
    t_change();
    t_gate_high();
    t_saturate();
    t_midreset();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule